// File: doc/BRIEF.md
# Direct-Mapped Branch Prediction Table

This block predicts the direction and destination of control-flow instructions for a deep in-order pipeline. In the first fetch stage the pipeline presents the fetch address and, one clock later, gets a hit flag, a predicted-taken flag and a predicted destination. When a branch or jump is resolved several stages later, the pipeline returns the instruction's address, its real outcome, its real destination, its class, and the prediction it was given at fetch. The block then trains the table and raises a mispredict flag one clock later.

The table is direct-mapped and carries no tag. A fixed slice of address bits selects the entry, so two addresses that share those bits share one entry and overwrite each other's history. Branches and jumps use the same table. A two-bit mode input picks the scheme on every lookup. Mode 0 is static not-taken. Mode 1 repeats the last recorded outcome. Modes 2 and 3 use a two-bit saturating counter. The table keeps learning in every mode, so the mode can be switched at run time without losing history.

Top module: `bpt_top`

## Requirements
- R1: While `rst` is high at a clock edge, every entry becomes invalid and, after that edge, `lk_hit`, `lk_taken`, `lk_target` and `up_mispredict` read 0.
- R2: The entry index is address bits `IDX_LSB` through `IDX_LSB+log2(DEPTH)-1` (bits 9:4 by default). Addresses that differ only outside those bits select the same entry.
- R3: Lookup results appear on the outputs one clock after `lk_pc` is sampled. When a lookup and an update hit the same entry at the same edge, the lookup returns the contents from before the update.
- R4: With `mode` = 0, `lk_hit` and `lk_taken` are 0 whatever the table holds.
- R5: A lookup of an invalid entry gives `lk_hit` = 0, `lk_taken` = 0 and `lk_target` = 0.
- R6: With `mode` = 1, a valid entry predicts taken exactly when its most recent recorded outcome was taken.
- R7: With `mode` = 2 or 3, each entry holds a counter from 0 to 3. The first update of an entry sets it to 2 if the outcome is taken and to 1 if not. Later updates add 1 on taken and subtract 1 on not-taken, saturating at 3 and 0. The entry predicts taken when the counter is 2 or 3.
- R8: An update with `up_kind` = 1 (jump) is recorded as taken whatever `up_taken` carries. `up_kind` = 0 marks a conditional branch.
- R9: Every accepted update writes `up_target` into the entry, and a hit returns that stored value on `lk_target`.
- R10: One clock after an update, `up_mispredict` is 1 when the predicted direction differs from the outcome, or when both are taken and `up_pred_target` differs from `up_target`. Otherwise it is 0, and it is also 0 one clock after any cycle with no update.
- R11: Updates train the table in all modes, including mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Scheme: 0 static not-taken, 1 last outcome, 2/3 two-bit counter |
| lk_pc | input | PCW | Fetch address to look up |
| lk_hit | output | 1 | Valid entry found (registered) |
| lk_taken | output | 1 | Predicted taken (registered) |
| lk_target | output | PCW | Predicted destination, 0 on a miss (registered) |
| up_valid | input | 1 | A resolved branch or jump is presented |
| up_pc | input | PCW | Address of the resolved instruction |
| up_taken | input | 1 | Resolved direction of a branch |
| up_target | input | PCW | Resolved destination |
| up_kind | input | 1 | 0 conditional branch, 1 jump |
| up_pred_taken | input | 1 | Direction that was predicted at fetch |
| up_pred_target | input | PCW | Destination that was predicted at fetch |
| up_mispredict | output | 1 | Prediction was wrong (registered, one clock after update) |

## Verification
Directed sequences walk one entry's counter up to saturation and back down, which separates the counter scheme from the last-outcome scheme: after a single not-taken following several taken outcomes, mode 1 flips but mode 2 does not. Two addresses that differ only above bit 9 show aliasing, and a same-edge lookup and update of one entry shows read-before-write ordering. A jump with a cleared taken input shows forced-taken training. Random traffic over a few aliasing addresses, with a random mode on each cycle and predictions that are partly consistent and partly random, exercises both mispredict causes (direction and destination) against a bench-side table model.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'd1;
  localparam ctr_t CTR_WEAK_T  = 2'd2;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_LAST   = 2'd1,
    MODE_SAT    = 2'd2,
    MODE_SAT_B  = 2'd3
  } mode_e;

  // saturating step of a two-bit counter
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == 2'd3) ? c : c + 2'd1;
    else       r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bpt_dir_state.sv
module bpt_dir_state
  import bpt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  mode_e           mode,
  input  logic [IDXW-1:0] lk_idx,
  input  logic            up_en,
  input  logic [IDXW-1:0] up_idx,
  input  logic            up_outcome,
  output logic            hit_q,
  output logic            taken_q
);
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] last_out;
  ctr_t             ctr [DEPTH];

  logic rd_hit;
  logic rd_dir;

  always_comb begin
    rd_hit = (mode != MODE_STATIC) && vld[lk_idx];
    rd_dir = (mode == MODE_LAST) ? last_out[lk_idx] : ctr[lk_idx][1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      hit_q   <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      hit_q   <= rd_hit;
      taken_q <= rd_hit && rd_dir;
      if (up_en) vld[up_idx] <= 1'b1;
    end
  end

  // history fields need no reset: the valid bits gate them
  always_ff @(posedge clk) begin
    if (up_en) begin
      last_out[up_idx] <= up_outcome;
      ctr[up_idx]      <= vld[up_idx] ? ctr_step(ctr[up_idx], up_outcome)
                                      : (up_outcome ? CTR_WEAK_T : CTR_WEAK_NT);
    end
  end
endmodule

// File: rtl/bpt_tgt_mem.sv
module bpt_tgt_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port, old data on collision
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/bpt_miss_eval.sv
module bpt_miss_eval #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           up_en,
  input  logic           outcome,
  input  logic [PCW-1:0] target,
  input  logic           pred_taken,
  input  logic [PCW-1:0] pred_target,
  output logic           miss_q
);
  logic dir_wrong;
  logic dst_wrong;

  always_comb begin
    dir_wrong = pred_taken != outcome;
    dst_wrong = pred_taken && outcome && (pred_target != target);
  end

  always_ff @(posedge clk) begin
    if (rst) miss_q <= 1'b0;
    else     miss_q <= up_en && (dir_wrong || dst_wrong);
  end
endmodule

// File: rtl/bpt_top.sv
module bpt_top
  import bpt_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int PCW     = 32,
  parameter int IDX_LSB = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode,
  input  logic [PCW-1:0] lk_pc,
  output logic           lk_hit,
  output logic           lk_taken,
  output logic [PCW-1:0] lk_target,
  input  logic           up_valid,
  input  logic [PCW-1:0] up_pc,
  input  logic           up_taken,
  input  logic [PCW-1:0] up_target,
  input  logic           up_kind,
  input  logic           up_pred_taken,
  input  logic [PCW-1:0] up_pred_target,
  output logic           up_mispredict
);
  localparam int IDXW = $clog2(DEPTH);

  logic [IDXW-1:0] lk_idx;
  logic [IDXW-1:0] up_idx;
  logic            outcome;
  logic [PCW-1:0]  tgt_raw;
  logic            hit_q;
  mode_e           mode_q;

  always_comb begin
    lk_idx  = lk_pc[IDX_LSB +: IDXW];
    up_idx  = up_pc[IDX_LSB +: IDXW];
    outcome = up_kind | up_taken;
    mode_q  = mode_e'(mode);
  end

  bpt_dir_state #(.DEPTH(DEPTH)) dir_i (
    .clk(clk), .rst(rst), .mode(mode_q),
    .lk_idx(lk_idx), .up_en(up_valid), .up_idx(up_idx), .up_outcome(outcome),
    .hit_q(hit_q), .taken_q(lk_taken)
  );

  bpt_tgt_mem #(.DEPTH(DEPTH), .DW(PCW)) tgt_i (
    .clk(clk), .we(up_valid), .waddr(up_idx), .wdata(up_target),
    .raddr(lk_idx), .rdata(tgt_raw)
  );

  bpt_miss_eval #(.PCW(PCW)) miss_i (
    .clk(clk), .rst(rst), .up_en(up_valid), .outcome(outcome),
    .target(up_target), .pred_taken(up_pred_taken),
    .pred_target(up_pred_target), .miss_q(up_mispredict)
  );

  assign lk_hit    = hit_q;
  assign lk_target = hit_q ? tgt_raw : '0;
endmodule

// File: rtl/bpt_chk.sv
module bpt_chk #(
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     mode,
  input logic           lk_hit,
  input logic           lk_taken,
  input logic [PCW-1:0] lk_target,
  input logic           up_valid,
  input logic           up_taken,
  input logic           up_kind,
  input logic           up_pred_taken,
  input logic           up_mispredict
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!lk_hit && !lk_taken && !up_mispredict));
  // R4
  static_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> (!lk_hit && !lk_taken));
  // R5
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (!lk_taken && lk_target == '0));
  // R10
  idle_no_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> !up_mispredict);
  // R10
  dir_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && (up_pred_taken != (up_kind || up_taken))) |=> up_mispredict);
  // R8
  jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_kind && !up_pred_taken) |=> up_mispredict);
endmodule

bind bpt_top bpt_chk #(.PCW(PCW)) chk_i (.*);

// File: tb/bpt_top_tb_top.sv
module bpt_top_tb_top;
  localparam int PCW = 32;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [PCW-1:0] lk_pc = '0;
  logic lk_hit, lk_taken, up_mispredict;
  logic [PCW-1:0] lk_target;
  logic up_valid = 1'b0, up_taken = 1'b0, up_kind = 1'b0, up_pred_taken = 1'b0;
  logic [PCW-1:0] up_pc = '0, up_target = '0, up_pred_target = '0;

  bpt_top dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // bench-side table model
  bit        m_vld [DEPTH];
  bit        m_last[DEPTH];
  bit [1:0]  m_ctr [DEPTH];
  bit [31:0] m_tgt [DEPTH];

  bit        have_exp = 0;
  bit        e_hit, e_taken, e_mis;
  bit [31:0] e_tgt;
  string     e_tag;

  function automatic int idx_of(input bit [31:0] pc);
    return int'(pc[9:4]);
  endfunction

  function automatic bit model_hit(input bit [1:0] md, input bit [31:0] pc);
    return (md != 2'd0) && m_vld[idx_of(pc)];
  endfunction

  function automatic bit model_taken(input bit [1:0] md, input bit [31:0] pc);
    int i = idx_of(pc);
    if (!model_hit(md, pc)) return 1'b0;
    return (md == 2'd1) ? m_last[i] : (m_ctr[i] >= 2);
  endfunction

  task automatic chk(input string what, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", e_tag, what, act, exp);
    end
  endtask

  task automatic check_prev();
    if (have_exp) begin
      chk("lk_hit", 32'(lk_hit), 32'(e_hit));
      chk("lk_taken", 32'(lk_taken), 32'(e_taken));
      chk("lk_target", lk_target, e_tgt);
      chk("up_mispredict", 32'(up_mispredict), 32'(e_mis));
    end
  endtask

  task automatic cyc(input string tag, input bit [1:0] md, input bit [31:0] lpc,
                     input bit uv, input bit [31:0] upc, input bit ut,
                     input bit [31:0] utg, input bit uk, input bit pt,
                     input bit [31:0] ptg);
    int ui;
    bit oc;
    @(negedge clk);
    check_prev();
    mode = md; lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    up_target = utg; up_kind = uk; up_pred_taken = pt; up_pred_target = ptg;
    e_tag   = tag;
    e_hit   = model_hit(md, lpc);
    e_taken = model_taken(md, lpc);
    e_tgt   = e_hit ? m_tgt[idx_of(lpc)] : 32'd0;
    oc      = uk | ut;
    e_mis   = uv && ((pt != oc) || (pt && oc && ptg != utg));
    have_exp = 1;
    if (uv) begin
      ui = idx_of(upc);
      if (!m_vld[ui]) m_ctr[ui] = oc ? 2'd2 : 2'd1;
      else if (oc && m_ctr[ui] != 2'd3) m_ctr[ui] = m_ctr[ui] + 2'd1;
      else if (!oc && m_ctr[ui] != 2'd0) m_ctr[ui] = m_ctr[ui] - 2'd1;
      m_vld[ui] = 1; m_last[ui] = oc; m_tgt[ui] = utg;
    end
  endtask

  task automatic look(input string tag, input bit [1:0] md, input bit [31:0] pc);
    cyc(tag, md, pc, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic train(input string tag, input bit [1:0] md, input bit [31:0] pc,
                       input bit t, input bit [31:0] tg);
    cyc(tag, md, 32'h0, 1, pc, t, tg, 0, model_taken(2'd2, pc), tg);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2016));
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    look("R1", 2'd1, 32'h100);
    look("R1", 2'd2, 32'h100);
    // R5: miss in all modes
    look("R5", 2'd2, 32'h230);
    // R7: counter walk on entry 0x100
    train("R7", 2'd2, 32'h100, 1, 32'h400);
    look("R7", 2'd2, 32'h100);
    train("R7", 2'd2, 32'h100, 1, 32'h400);
    train("R7", 2'd2, 32'h100, 1, 32'h400);
    train("R7", 2'd2, 32'h100, 0, 32'h400);
    look("R7", 2'd2, 32'h100);
    look("R6", 2'd1, 32'h100);
    train("R7", 2'd3, 32'h100, 0, 32'h400);
    look("R7", 2'd3, 32'h100);
    train("R7", 2'd2, 32'h100, 0, 32'h400);
    train("R7", 2'd2, 32'h100, 0, 32'h400);
    look("R7", 2'd2, 32'h100);
    // R11/R4: training in mode 0, then mode 0 lookup stays quiet
    cyc("R11", 2'd0, 32'h0, 1, 32'h140, 0, 32'h900, 0, 0, 0);
    look("R4", 2'd0, 32'h140);
    look("R11", 2'd1, 32'h140);
    // R2: alias 0x140 and 0x540 share bits 9:4
    train("R2", 2'd1, 32'h540, 1, 32'hA00);
    look("R2", 2'd1, 32'h140);
    look("R9", 2'd2, 32'h140);
    // R8: jump with up_taken low trains as taken, predicted not-taken -> miss
    cyc("R8", 2'd1, 32'h0, 1, 32'h180, 0, 32'hB00, 1, 0, 0);
    look("R8", 2'd1, 32'h180);
    // R3: same-edge update and lookup of 0x180 returns old contents
    cyc("R3", 2'd1, 32'h180, 1, 32'h180, 0, 32'hC00, 0, 1, 32'hB00);
    look("R3", 2'd1, 32'h180);
    // R10: destination mismatch, then direction and target correct
    cyc("R10", 2'd1, 32'h0, 1, 32'h1C0, 1, 32'hD00, 0, 1, 32'hD04);
    cyc("R10", 2'd1, 32'h0, 1, 32'h1C0, 1, 32'hD00, 0, 1, 32'hD00);
    cyc("R10", 2'd1, 32'h0, 1, 32'h1C0, 0, 32'hD00, 0, 0, 32'h123);
    look("R10", 2'd1, 32'h1C0);
    // random traffic over a few aliasing addresses
    for (int n = 0; n < 3000; n++) begin
      bit [31:0] lp, upc, tg, ptg;
      bit [1:0] md;
      bit uv, ut, uk, pt;
      md  = 2'($urandom % 4);
      lp  = {20'($urandom % 4), 6'($urandom % 6), 6'h0} >> 2;
      upc = {20'($urandom % 4), 6'($urandom % 6), 6'h0} >> 2;
      uv  = ($urandom % 2) == 0;
      ut  = ($urandom % 3) != 0;
      uk  = ($urandom % 6) == 0;
      tg  = 32'h1000 + 32'(($urandom % 3) * 4);
      if ($urandom % 2) begin
        pt = model_taken(md, upc); ptg = m_tgt[idx_of(upc)];
      end else begin
        pt = 1'($urandom); ptg = 32'h1000 + 32'(($urandom % 3) * 4);
      end
      cyc("R7", md, lp, uv, upc, ut, tg, uk, pt, ptg);
    end
    look("R6", 2'd1, 32'h0);
    // R1: reset mid-run invalidates all entries
    @(negedge clk);
    check_prev();
    have_exp = 0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    look("R1", 2'd2, 32'h100);
    look("R1", 2'd1, 32'h140);
    @(negedge clk);
    check_prev();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule